// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog that counts system clock cycles while it is enabled. Software picks one of four power-of-two time-out lengths with a 2-bit select. When the selected length runs out, the block raises an interrupt flag and opens a fixed grace window. If software restarts the watchdog inside that window, the flag drops and nothing else happens. If it does not, the block issues a one-cycle system reset request. The watchdog then starts counting again from zero without being turned off.

The enable and select inputs are plain levels. Each is registered once inside the block. The restart input is a single-cycle strobe. A power-on reset leaves the watchdog disabled, with the select register at its shortest setting. The interval base, the exponent step between settings and the grace width are all parameters. By default they give 2^17, 2^20, 2^23 and 2^26 cycles, plus a 512-cycle grace window.

Top module: `wdt_two_stage`

## Requirements
- R1: While the power-on reset `rst_n` is low, and in the first cycle after it is released, `irq_flag` and `rst_req` are 0. The enable register resets to 0 (disabled) and the select register resets to 00.
- R2: Select value s (00, 01, 10, 11) gives an interrupt time-out of T = 2^(BASE_EXP + STEP_EXP*s) cycles. The defaults of 17 and 3 give 2^17, 2^20, 2^23 and 2^26.
- R3: After a restart strobe is sampled at clock edge e0 with the watchdog enabled, `irq_flag` is 0 through edge e0+T-1 and rises at edge e0+T. It then stays high until a restart, a watchdog reset or a disable.
- R4: If no restart arrives, `rst_req` goes high at edge e0+T+G, where G = 2^GRACE_W (512 by default). It stays high for exactly one cycle.
- R5: At the edge where `rst_req` rises, `irq_flag` returns to 0 and the watchdog stays enabled. Counting restarts from zero, so the next interrupt comes at edge e0+2T+G.
- R6: A restart strobe sampled while the flag is high clears `irq_flag` at that edge and cancels the grace window, so no `rst_req` follows. The next interrupt comes T cycles after that strobe.
- R7: A change of `wd_sel` is registered at the next edge and used for the comparison at the edge after that. The count is not cleared. If the count already exceeds the new limit, the interrupt fires at that second edge.
- R8: `wd_en` is registered once. While the registered enable is 0, the counters and `irq_flag` are cleared at each edge and neither output is raised. Restart strobes have no effect in that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wd_en | input | 1 | Watchdog enable level, registered once |
| wd_kick | input | 1 | Single-cycle restart strobe |
| wd_sel | input | 2 | Time-out select level, registered once |
| irq_flag | output | 1 | Interrupt flag, high during the grace window |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every result is due at a fixed edge counted from the edge that samples the restart strobe. The interrupt flag is due T edges later and the reset request T+G edges later. A select or enable change adds one edge for its input register. The bench drives inputs on the falling edge, steps one rising edge at a time and samples 1 ns after it. Each check therefore lands on the exact edge index worked out from these counts. In every case the bench also checks the edge just before the event, so an early output is caught as well as a late one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Exponent of the interrupt time-out chosen by a select code.
  function automatic int unsigned wdt_exp(input logic [1:0] sel,
                                          input int unsigned base,
                                          input int unsigned step);
    return base + step * int'(sel);
  endfunction

  // Largest exponent reachable: sizes the interval counter.
  function automatic int unsigned wdt_max_exp(input int unsigned base,
                                              input int unsigned step);
    return base + 3 * step;
  endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  input  logic [1:0] sel_in,
  output logic       en_q,
  output logic [1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
    end else begin
      en_q  <= en_in;
      sel_q <= sel_in;
    end
  end
endmodule

// File: rtl/wdt_interval_cnt.sv
module wdt_interval_cnt #(
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned STEP_EXP = 3,
  localparam int unsigned CNT_W = wdt_pkg::wdt_max_exp(BASE_EXP, STEP_EXP)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       hold,
  input  logic [1:0] sel_q,
  output logic       at_limit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim_full;
  logic [CNT_W-1:0] lim_m1;

  always_comb begin
    lim_full = ({{CNT_W{1'b0}}, 1'b1} << wdt_pkg::wdt_exp(sel_q, BASE_EXP, STEP_EXP)) - 1'b1;
    lim_m1   = lim_full[CNT_W-1:0];
    at_limit = (cnt >= lim_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (!hold && !at_limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_grace_cnt.sv
module wdt_grace_cnt #(
  parameter int unsigned GRACE_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic last
);
  logic [GRACE_W-1:0] gcnt;

  assign last = &gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gcnt <= '0;
    else if (clr)  gcnt <= '0;
    else           gcnt <= gcnt + 1'b1;
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned STEP_EXP = 3,
  parameter int unsigned GRACE_W  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       irq_flag,
  output logic       rst_req
);
  logic       en_q;
  logic [1:0] sel_q;
  logic       at_limit;
  logic       grace_last;
  logic       kick_hit;
  logic       expire;
  logic       grace_done;
  logic       int_clr;
  logic       grace_clr;

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .en_in(wd_en), .sel_in(wd_sel),
    .en_q(en_q), .sel_q(sel_q)
  );

  // Named events, also watched by the checker.
  assign kick_hit   = en_q & wd_kick;
  assign expire     = en_q & ~irq_flag & ~wd_kick & at_limit;
  assign grace_done = en_q & irq_flag & ~wd_kick & grace_last;
  assign int_clr    = ~en_q | wd_kick | grace_done;
  assign grace_clr  = ~en_q | wd_kick | ~irq_flag;

  wdt_interval_cnt #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)) u_int (
    .clk(clk), .rst_n(rst_n), .clr(int_clr), .hold(irq_flag),
    .sel_q(sel_q), .at_limit(at_limit)
  );

  wdt_grace_cnt #(.GRACE_W(GRACE_W)) u_grace (
    .clk(clk), .rst_n(rst_n), .clr(grace_clr), .last(grace_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      rst_req <= grace_done;
      if (int_clr)      irq_flag <= 1'b0;
      else if (expire)  irq_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int unsigned GRACE_W = 9
) (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic kick_hit,
  input logic expire,
  input logic irq_flag,
  input logic rst_req
);
  localparam int unsigned GRACE_LEN = 1 << GRACE_W;
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= 0;
    else if (!irq_flag) run <= 0;
    else                run <= run + 1;
  end

  // R4: request only after exactly the grace window with the flag high
  p_grace_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> run == GRACE_LEN);
  // R4: request lasts one cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R5: flag is low when the request is out
  p_irq_clear_on_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !irq_flag);
  // R6: restart drops the flag and blocks the request
  p_kick_cancels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hit |=> !irq_flag && !rst_req);
  // R8: disabled state raises nothing
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_flag && !rst_req);
  // R3: flag rises only from an expiry
  p_irq_from_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(expire));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.GRACE_W(GRACE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .kick_hit(kick_hit),
  .expire(expire), .irq_flag(irq_flag), .rst_req(rst_req)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  localparam int unsigned BASE = 3;
  localparam int unsigned STEP = 1;
  localparam int unsigned GW   = 3;
  localparam int unsigned G    = 1 << GW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_en = 1'b0;
  logic wd_kick = 1'b0;
  logic [1:0] wd_sel = 2'b00;
  logic irq_flag, rst_req;
  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;

  wdt_two_stage #(.BASE_EXP(BASE), .STEP_EXP(STEP), .GRACE_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .wd_kick(wd_kick),
    .wd_sel(wd_sel), .irq_flag(irq_flag), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic stepn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // restart strobe sampled at the next edge (e0); returns after e0
  task automatic kick();
    @(negedge clk); wd_kick = 1'b1;
    step();
    wd_kick = 1'b0;
  endtask

  function automatic int tlen(input int s);
    return 1 << (BASE + STEP * s);
  endfunction

  initial begin
    // watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    stepn(2);
    check("R1 irq in reset", irq_flag, 0);
    check("R1 req in reset", rst_req, 0);
    rst_n = 1'b1;
    step();
    check("R1 irq after reset", irq_flag, 0);
    check("R1 req after reset", rst_req, 0);

    // R8: disabled, strobes ignored, nothing fires
    pulses = 0;
    kick();
    for (int i = 0; i < 100; i++) begin step(); pulses += irq_flag + rst_req; end
    check("R8 disabled outputs", pulses, 0);

    // R2 R3 R4 R5 sweep over all selects
    for (int s = 0; s < 4; s++) begin
      int t;
      t = tlen(s);
      @(negedge clk); wd_en = 1'b1; wd_sel = 2'(s);
      stepn(2);
      kick();                       // now at e0
      stepn(t - 1);
      check($sformatf("R3 sel%0d irq before T", s), irq_flag, 0);
      step();
      check($sformatf("R2 sel%0d irq at T", s), irq_flag, 1);
      stepn(G - 1);
      check($sformatf("R4 sel%0d req before grace end", s), rst_req, 0);
      check($sformatf("R3 sel%0d irq held", s), irq_flag, 1);
      step();
      check($sformatf("R4 sel%0d req at T+G", s), rst_req, 1);
      check($sformatf("R5 sel%0d irq cleared", s), irq_flag, 0);
      step();
      check($sformatf("R4 sel%0d req one cycle", s), rst_req, 0);
      stepn(t - 2);
      check($sformatf("R5 sel%0d no early irq", s), irq_flag, 0);
      step();
      check($sformatf("R5 sel%0d irq at 2T+G", s), irq_flag, 1);
      kick();
      check($sformatf("R6 sel%0d kick clears", s), irq_flag, 0);
      @(negedge clk); wd_en = 1'b0;
      stepn(2);
    end

    // R6: restart inside grace window cancels reset
    @(negedge clk); wd_en = 1'b1; wd_sel = 2'd0;
    stepn(2);
    kick();
    stepn(tlen(0) + 3);
    check("R6 irq up", irq_flag, 1);
    kick();
    check("R6 irq dropped", irq_flag, 0);
    pulses = 0;
    for (int i = 0; i < tlen(0) - 1; i++) begin step(); pulses += rst_req + irq_flag; end
    check("R6 no reset or irq", pulses, 0);
    step();
    check("R6 irq T after kick", irq_flag, 1);

    // R7: lower select mid-count without clearing
    @(negedge clk); wd_sel = 2'd3;
    step();
    kick();
    stepn(20);
    @(negedge clk); wd_sel = 2'd0;
    step();
    check("R7 old limit at first edge", irq_flag, 0);
    step();
    check("R7 new limit applied", irq_flag, 1);

    // R8: disable while flag high clears it after register latency
    @(negedge clk); wd_en = 1'b0;
    step();
    check("R8 en register latency", irq_flag, 1);
    step();
    check("R8 disable clears irq", irq_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule